// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block turns two asynchronous control levels, a light sleep request and a deep sleep request, into the operating state of a data converter. Both levels are first passed through synchronizer flops. The block then drives a decoded state code, an enable that lets the conversion datapath produce new samples, and a hold enable. While the hold enable is high, the output registers downstream keep the last sample they captured rather than being cleared.

The deep sleep request always has priority over the light one. When both requests are gone, the block does not return to normal operation at once. It first spends a fixed recovery interval counted in clock cycles. The interval is short after light sleep and long after deep sleep. The long interval also applies to any recovery that follows a deep sleep which happened since the block was last ready. The ready flag, and with it the conversion enable, rises only after that interval has elapsed.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: During and directly after synchronous reset the outputs are state_o=0 (run), ready_o=1, conv_en_o=1, hold_o=0.
- R2: With both requests low and no recovery pending, the block stays in run (state_o=0), with conv_en_o=1 and hold_o=0.
- R3: When sleep_lt_i is high and sleep_dp_i is low, the block enters light sleep (state_o=1), with ready_o=0, conv_en_o=0 and hold_o=1.
- R4: When sleep_dp_i is high, the block enters deep sleep (state_o=2) whatever the level of sleep_lt_i, with ready_o=0, conv_en_o=0 and hold_o=1.
- R5: After light sleep ends, state_o=3 (recovering) holds for exactly LT_WAKE_CYC cycles. Then state_o returns to 0 and ready_o rises.
- R6: After deep sleep ends, the recovering state lasts exactly DP_WAKE_CYC cycles.
- R7: If sleep_dp_i rises during a light-sleep recovery, the block goes straight to deep sleep. The recovery that follows uses DP_WAKE_CYC.
- R8: If deep sleep is followed by light sleep before the block is ready again, the recovery uses DP_WAKE_CYC. A light-sleep request during a recovery returns the block to light sleep, and the next recovery restarts from the full count.
- R9: A change on either request takes effect at the outputs on the third rising clock edge after it is first sampled. A request held for a single cycle still produces a full sleep-and-recover sequence.
- R10: conv_en_o always equals ready_o, and hold_o always equals the inverse of ready_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sleep_lt_i | input | 1 | Light sleep request, asynchronous level |
| sleep_dp_i | input | 1 | Deep sleep request, asynchronous level, dominant |
| state_o | output | 2 | 0 run, 1 light sleep, 2 deep sleep, 3 recovering |
| hold_o | output | 1 | Keep downstream output registers frozen |
| conv_en_o | output | 1 | Conversion datapath enable |
| ready_o | output | 1 | Accurate conversions available |

## Verification
A stuck or mis-set long-recovery flag shows up only at the end of a recovery. ready_o then rises after the short count where the long one was due, or the reverse, so it is seen on the first deep-then-light sequence. A timer that loads the wrong count moves the rising edge of ready_o by that many cycles. A priority or decode fault appears on state_o three edges after the offending request. The bench compares every output on every cycle, so each of these errors is reported in the cycle where it first appears.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_LT   = 2'd1,
    MODE_DP   = 2'd2,
    MODE_WAKE = 2'd3
  } pmc_mode_e;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[0] <= '0;
          else       chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[g] <= '0;
          else       chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pmc_wake_timer.sv
module pmc_wake_timer #(
  parameter int SHORT_CYC = 16,
  parameter int LONG_CYC  = 20000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  input  logic long_i,
  input  logic run_i,
  output logic done_o
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= long_i ? LONG_LD : SHORT_LD;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      lt_s_i,
  input  logic      dp_s_i,
  input  logic      tmr_done_i,
  output logic      tmr_load_o,
  output logic      tmr_long_o,
  output logic      tmr_run_o,
  output pmc_mode_e mode_o,
  output logic      ready_o,
  output logic      hold_o,
  output logic      conv_en_o
);
  pmc_mode_e mode_q, mode_nxt;
  logic      long_q;
  logic      ready_q, hold_q, conv_q;

  always_comb begin
    if (dp_s_i) begin
      mode_nxt = MODE_DP;
    end else if (lt_s_i) begin
      mode_nxt = MODE_LT;
    end else begin
      unique case (mode_q)
        MODE_RUN:  mode_nxt = MODE_RUN;
        MODE_LT:   mode_nxt = MODE_WAKE;
        MODE_DP:   mode_nxt = MODE_WAKE;
        MODE_WAKE: mode_nxt = tmr_done_i ? MODE_RUN : MODE_WAKE;
        default:   mode_nxt = MODE_RUN;
      endcase
    end
  end

  assign tmr_load_o = (mode_q == MODE_LT || mode_q == MODE_DP) && (mode_nxt == MODE_WAKE);
  assign tmr_long_o = long_q;
  assign tmr_run_o  = (mode_q == MODE_WAKE);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q  <= MODE_RUN;
      long_q  <= 1'b0;
      ready_q <= 1'b1;
      hold_q  <= 1'b0;
      conv_q  <= 1'b1;
    end else begin
      mode_q  <= mode_nxt;
      if (mode_nxt == MODE_DP)       long_q <= 1'b1;
      else if (mode_nxt == MODE_RUN) long_q <= 1'b0;
      ready_q <= (mode_nxt == MODE_RUN);
      hold_q  <= (mode_nxt != MODE_RUN);
      conv_q  <= (mode_nxt == MODE_RUN);
    end
  end

  assign mode_o    = mode_q;
  assign ready_o   = ready_q;
  assign hold_o    = hold_q;
  assign conv_en_o = conv_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int LT_WAKE_CYC = 16,
  parameter int DP_WAKE_CYC = 20000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       sleep_lt_i,
  input  logic       sleep_dp_i,
  output logic [1:0] state_o,
  output logic       hold_o,
  output logic       conv_en_o,
  output logic       ready_o
);
  import pmc_pkg::*;

  logic [1:0] req_s;
  logic       tmr_load, tmr_long, tmr_run, tmr_done;
  pmc_mode_e  mode;

  pmc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   ({sleep_dp_i, sleep_lt_i}),
    .q_o   (req_s)
  );

  pmc_wake_timer #(.SHORT_CYC(LT_WAKE_CYC), .LONG_CYC(DP_WAKE_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (tmr_load),
    .long_i (tmr_long),
    .run_i  (tmr_run),
    .done_o (tmr_done)
  );

  pmc_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .lt_s_i     (req_s[0]),
    .dp_s_i     (req_s[1]),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_long_o (tmr_long),
    .tmr_run_o  (tmr_run),
    .mode_o     (mode),
    .ready_o    (ready_o),
    .hold_o     (hold_o),
    .conv_en_o  (conv_en_o)
  );

  assign state_o = mode;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int LT_WAKE_CYC = 16,
  parameter int DP_WAKE_CYC = 20000
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       sleep_lt_i,
  input logic       sleep_dp_i,
  input logic [1:0] state_o,
  input logic       hold_o,
  input logic       conv_en_o,
  input logic       ready_o
);
  logic [1:0] warm_cnt;
  logic       warm;
  int         wake_len;

  always_ff @(posedge clk_i) begin
    if (rst_i) warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 1'b1;
  end
  assign warm = (warm_cnt == 2'd3);

  always_ff @(posedge clk_i) begin
    if (rst_i)               wake_len <= 0;
    else if (state_o == 2'd3) wake_len <= wake_len + 1;
    else                     wake_len <= 0;
  end

  // R4
  a_r4_deep_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    warm && $past(sleep_dp_i, 3) |-> state_o == 2'd2);

  // R3
  a_r3_light_sleep: assert property (@(posedge clk_i) disable iff (rst_i)
    warm && $past(sleep_lt_i, 3) && !$past(sleep_dp_i, 3) |-> state_o == 2'd1);

  // R10
  a_r10_out_agree: assert property (@(posedge clk_i) disable iff (rst_i)
    (conv_en_o == ready_o) && (hold_o == !ready_o));

  // R5 / R6
  a_r5_wake_len: assert property (@(posedge clk_i) disable iff (rst_i)
    warm && state_o == 2'd0 && $past(state_o) == 2'd3 |->
      (wake_len == LT_WAKE_CYC || wake_len == DP_WAKE_CYC));

  // R2
  a_r2_run_only_after_wake: assert property (@(posedge clk_i) disable iff (rst_i)
    warm && state_o == 2'd0 && $past(state_o) != 2'd0 |-> $past(state_o) == 2'd3);
endmodule

bind pwr_mode_ctrl pmc_checker #(
  .LT_WAKE_CYC(LT_WAKE_CYC),
  .DP_WAKE_CYC(DP_WAKE_CYC)
) u_pmc_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .sleep_lt_i (sleep_lt_i),
  .sleep_dp_i (sleep_dp_i),
  .state_o    (state_o),
  .hold_o     (hold_o),
  .conv_en_o  (conv_en_o),
  .ready_o    (ready_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  localparam int LT = 16;
  localparam int DP = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lt  = 1'b0;
  logic       dp  = 1'b0;
  logic [1:0] state;
  logic       hold, conv_en, ready;

  int total = 0;
  int bad   = 0;
  string tag = "";

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.LT_WAKE_CYC(LT), .DP_WAKE_CYC(DP)) u0 (
    .clk_i(clk), .rst_i(rst), .sleep_lt_i(lt), .sleep_dp_i(dp),
    .state_o(state), .hold_o(hold), .conv_en_o(conv_en), .ready_o(ready)
  );

  // behavioural reference: two-deep request queue, mode, remaining count
  bit lt_q[$];
  bit dp_q[$];
  int m_st = 0, m_left = 0;
  bit m_long = 0;

  always @(posedge clk) begin
    if (rst) begin
      lt_q = '{0, 0}; dp_q = '{0, 0};
      m_st = 0; m_left = 0; m_long = 0;
    end else begin
      bit l2, d2;
      l2 = lt_q.pop_front(); d2 = dp_q.pop_front();
      lt_q.push_back(lt); dp_q.push_back(dp);
      if (d2) begin m_st = 2; m_long = 1; end
      else if (l2) m_st = 1;
      else if (m_st == 1 || m_st == 2) begin
        m_st = 3; m_left = m_long ? DP : LT;
      end else if (m_st == 3) begin
        m_left--;
        if (m_left == 0) begin m_st = 0; m_long = 0; end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      string r;
      if (tag != "") r = tag;
      else case (m_st)
        0: r = "R2"; 1: r = "R3"; 2: r = "R4";
        default: r = m_long ? "R6" : "R5";
      endcase
      check(r, int'(state), m_st, "state");
      check(r, int'(ready), (m_st == 0) ? 1 : 0, "ready");
      check("R10", int'(conv_en), int'(ready), "conv_en vs ready");
      check("R10", int'(hold), int'(!ready), "hold vs ready");
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    cyc(3);
    // R1: outputs during reset
    check("R1", int'(state), 0, "state in reset");
    check("R1", int'(ready), 1, "ready in reset");
    check("R1", int'(conv_en), 1, "conv_en in reset");
    check("R1", int'(hold), 0, "hold in reset");
    rst = 1'b0;
    cyc(1);
    check("R1", int'(state), 0, "state after reset");
    cyc(10);
    // R3 then R5
    lt = 1; cyc(10); lt = 0; cyc(LT + 8);
    // R4: both high, then deep only; R6 recovery
    lt = 1; dp = 1; cyc(8); lt = 0; cyc(6); dp = 0; cyc(DP + 8);
    // R7: deep request during light recovery
    tag = "R7";
    lt = 1; cyc(6); lt = 0; cyc(8); dp = 1; cyc(3); dp = 0; cyc(DP + 8);
    // R8: deep then light before ready -> long recovery
    tag = "R8";
    dp = 1; cyc(6); lt = 1; dp = 0; cyc(6); lt = 0; cyc(DP + 8);
    // R8: light request interrupts short recovery, restart full count
    lt = 1; cyc(5); lt = 0; cyc(9); lt = 1; cyc(4); lt = 0; cyc(LT + 8);
    // R9: single-cycle pulses
    tag = "R9";
    lt = 1; cyc(1); lt = 0; cyc(LT + 8);
    dp = 1; cyc(1); dp = 0; cyc(DP + 8);
    tag = "";
    cyc(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule